// File: doc/BRIEF.md
# Modem Status Flags and Interrupt Request

This block keeps the five low bits of a four-level FSK modem's status byte and raises an interrupt request from them. A data-pump sequencer sends it single-cycle event pulses: a receive task was loaded too late, a CRC-checked task has finished (with its pass/fail verdict), or an S symbol has gone by (with its 2-bit value). The host bus sends a strobe each time it reads the status byte. The command path sends a strobe for a reset task. Two mode inputs select transmit or receive and power-save.

Each flag follows its own set and clear rules. The overflow and symbol-ready flags clear after the host reads them. The CRC flag does not, so a failure stays visible until a reset task or a mode change. A change of either mode bit, or a reset task, clears everything, and that clear wins over any event in the same cycle. The interrupt line is high whenever the overflow or symbol-ready flag is held.

Top module: `modem_status_irq`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it, `status_o` is 00000 and `irq_o` is 0.
- R2: Field layout of `status_o`: bit 4 is receive overflow, bit 3 is CRC error, bit 2 is symbol ready, and bits 1:0 are the symbol value. In receive mode (`mode_tx_i`=0), a pulse on `ev_late_i` sets bit 4 from the next clock edge on.
- R3: A pulse on `rd_stb_i` clears bits 4 and 2 at the next edge. If a set event for one of these flags arrives in the same cycle as the read, that flag is set after the edge.
- R4: In receive mode, a pulse on `ev_crc_done_i` loads bit 3 with `crc_fail_i` (1 = failed, 0 = passed) at the next edge. A status read leaves bit 3 unchanged.
- R5: A pulse on `ev_sym_i` sets bit 2 in either mode. In receive mode it also loads bits 1:0 with `sym_val_i`, and they keep that value until the next such capture or a clear.
- R6: A pulse on `rst_task_i` makes all of `status_o` 00000 after the next edge, even if set events arrive in the same cycle.
- R7: When either `mode_tx_i` or `mode_psave_i` differs from its value in the previous cycle, all of `status_o` is 00000 after the next edge, even if set events arrive in the same cycle.
- R8: In transmit mode (`mode_tx_i`=1), `ev_late_i`, `ev_crc_done_i` and the symbol value have no effect: bits 4, 3 and 1:0 stay 0.
- R9: `irq_o` is 1 exactly when bit 4 or bit 2 of `status_o` is 1. It falls in the same cycle that those flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_late_i | input | 1 | Pulse: receive task loaded too late |
| ev_crc_done_i | input | 1 | Pulse: CRC-checked task finished |
| crc_fail_i | input | 1 | CRC verdict for that task, 1 = failed |
| ev_sym_i | input | 1 | Pulse: S symbol received or sent |
| sym_val_i | input | 2 | Value of the received S symbol |
| rd_stb_i | input | 1 | Host read of the status byte |
| rst_task_i | input | 1 | Pulse: reset task |
| mode_tx_i | input | 1 | 1 = transmit, 0 = receive |
| mode_psave_i | input | 1 | Power-save mode bit |
| status_o | output | 5 | Status bits 4:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
Every flag is a single register stage. A set, load or clear that arrives in one cycle shows on `status_o` after the next rising edge. `irq_o` follows those registers with no further delay. The bench drives each stimulus right after a falling edge and removes it one falling edge later. It compares `status_o` and `irq_o` at that second falling edge, when exactly one rising edge has passed. A mode change takes effect one edge after the mode input moves, so the check after a mode toggle is made at the same falling edge.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int SYM_W   = 2;
    localparam int STAT_W  = SYM_W + 3;
    localparam int POS_OVF = SYM_W + 2;
    localparam int POS_CRC = SYM_W + 1;
    localparam int POS_RDY = SYM_W;

    typedef struct packed {
        logic             ovf;
        logic             crc;
        logic             rdy;
        logic [SYM_W-1:0] sval;
    } stat_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_CLR  = 2'd2
    } flag_act_e;

    // Priority: forced clear, then new data, then read-clear, then hold.
    function automatic flag_act_e pick_act(input logic clr, input logic load,
                                           input logic rd, input logic rd_clears);
        if (clr)                  return ACT_CLR;
        else if (load)            return ACT_LOAD;
        else if (rd && rd_clears) return ACT_CLR;
        else                      return ACT_HOLD;
    endfunction

endpackage

// File: rtl/mstat_mode_watch.sv
module mstat_mode_watch #(
    parameter int N_MODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_MODE-1:0] mode_i,
    output logic              chg_o
);
    logic [N_MODE-1:0] mode_q;

    // During reset the copy tracks the inputs, so leaving reset is not a change.
    always_ff @(posedge clk) begin
        mode_q <= mode_i;
    end

    assign chg_o = !rst && (mode_q != mode_i);
endmodule

// File: rtl/mstat_flag.sv
module mstat_flag
    import mstat_pkg::*;
#(
    parameter int   W         = 1,
    parameter logic RD_CLEARS = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         rd_i,
    output logic [W-1:0] q_o
);
    flag_act_e   act;
    logic        rd_eff;
    logic [W-1:0] q;

    generate
        if (RD_CLEARS) begin : g_rdclr
            assign rd_eff = rd_i;
        end else begin : g_sticky
            assign rd_eff = 1'b0;
        end
    endgenerate

    always_comb act = pick_act(clr_i, load_i, rd_eff, RD_CLEARS);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLR:  q <= '0;
                ACT_LOAD: q <= load_val_i;
                default:  q <= q;
            endcase
        end
    end

    assign q_o = q;
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq
    import mstat_pkg::*;
#(
    parameter int SW = mstat_pkg::SYM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_late_i,
    input  logic          ev_crc_done_i,
    input  logic          crc_fail_i,
    input  logic          ev_sym_i,
    input  logic [SW-1:0] sym_val_i,
    input  logic          rd_stb_i,
    input  logic          rst_task_i,
    input  logic          mode_tx_i,
    input  logic          mode_psave_i,
    output logic [SW+2:0] status_o,
    output logic          irq_o
);
    localparam int N_MODE = 2;

    logic  mode_chg;
    logic  clr_all;
    logic  rx_mode;
    stat_t st;

    mstat_mode_watch #(.N_MODE(N_MODE)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .mode_i ({mode_psave_i, mode_tx_i}),
        .chg_o  (mode_chg)
    );

    assign clr_all = rst_task_i || mode_chg;
    assign rx_mode = !mode_tx_i;

    // Overflow: receive only, read-clear
    mstat_flag #(.W(1), .RD_CLEARS(1'b1)) u_ovf (
        .clk(clk), .rst(rst), .clr_i(clr_all),
        .load_i(ev_late_i && rx_mode), .load_val_i(1'b1),
        .rd_i(rd_stb_i), .q_o(st.ovf)
    );

    // CRC verdict: receive only, survives status reads
    mstat_flag #(.W(1), .RD_CLEARS(1'b0)) u_crc (
        .clk(clk), .rst(rst), .clr_i(clr_all),
        .load_i(ev_crc_done_i && rx_mode), .load_val_i(crc_fail_i),
        .rd_i(rd_stb_i), .q_o(st.crc)
    );

    // Symbol ready: either mode, read-clear
    mstat_flag #(.W(1), .RD_CLEARS(1'b1)) u_rdy (
        .clk(clk), .rst(rst), .clr_i(clr_all),
        .load_i(ev_sym_i), .load_val_i(1'b1),
        .rd_i(rd_stb_i), .q_o(st.rdy)
    );

    // Symbol value: receive only, held across reads
    mstat_flag #(.W(SW), .RD_CLEARS(1'b0)) u_sval (
        .clk(clk), .rst(rst), .clr_i(clr_all),
        .load_i(ev_sym_i && rx_mode), .load_val_i(sym_val_i),
        .rd_i(rd_stb_i), .q_o(st.sval)
    );

    assign status_o = st;
    assign irq_o    = st.ovf | st.rdy;
endmodule

// File: rtl/mstat_checker.sv
module mstat_checker #(
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_late_i,
    input logic          ev_crc_done_i,
    input logic          ev_sym_i,
    input logic          rd_stb_i,
    input logic          rst_task_i,
    input logic          mode_tx_i,
    input logic          mode_psave_i,
    input logic [SW+2:0] status_o,
    input logic          irq_o
);
    localparam int B_OVF = SW + 2;
    localparam int B_CRC = SW + 1;
    localparam int B_RDY = SW;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (status_o == '0 && !irq_o)); // R1

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (ev_late_i && !mode_tx_i && !rst_task_i && mode_tx_i == $past(mode_tx_i)
         && mode_psave_i == $past(mode_psave_i)) |=> status_o[B_OVF]); // R2

    AST_READ_CLR: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && !ev_late_i && !ev_sym_i) |=> (!status_o[B_OVF] && !status_o[B_RDY])); // R3

    AST_READ_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && ev_sym_i && !rst_task_i && mode_tx_i == $past(mode_tx_i)
         && mode_psave_i == $past(mode_psave_i)) |=> status_o[B_RDY]); // R3

    AST_CRC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && !ev_crc_done_i && !rst_task_i && mode_tx_i == $past(mode_tx_i)
         && mode_psave_i == $past(mode_psave_i)) |=> $stable(status_o[B_CRC])); // R4

    AST_TASK_CLR: assert property (@(posedge clk) disable iff (rst)
        rst_task_i |=> (status_o == '0)); // R6

    AST_MODE_CLR: assert property (@(posedge clk) disable iff (rst)
        (mode_tx_i != $past(mode_tx_i) || mode_psave_i != $past(mode_psave_i))
        |=> (status_o == '0)); // R7

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_tx_i && $past(mode_tx_i)) |-> (!status_o[B_OVF] && !status_o[B_CRC]
                                             && status_o[SW-1:0] == '0)); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(ev_late_i || ev_sym_i)); // R9
endmodule

bind modem_status_irq mstat_checker #(.SW(SW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_late_i    (ev_late_i),
    .ev_crc_done_i(ev_crc_done_i),
    .ev_sym_i     (ev_sym_i),
    .rd_stb_i     (rd_stb_i),
    .rst_task_i   (rst_task_i),
    .mode_tx_i    (mode_tx_i),
    .mode_psave_i (mode_psave_i),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/tb_modem_status_irq.sv
module tb_modem_status_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_late = 1'b0, ev_crc = 1'b0, crc_fail = 1'b0, ev_sym = 1'b0;
    logic [1:0] sym_val = 2'b00;
    logic       rd = 1'b0, rtask = 1'b0, mtx = 1'b0, mps = 1'b0;
    logic [4:0] status;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    modem_status_irq dut (
        .clk(clk), .rst(rst),
        .ev_late_i(ev_late), .ev_crc_done_i(ev_crc), .crc_fail_i(crc_fail),
        .ev_sym_i(ev_sym), .sym_val_i(sym_val), .rd_stb_i(rd),
        .rst_task_i(rtask), .mode_tx_i(mtx), .mode_psave_i(mps),
        .status_o(status), .irq_o(irq)
    );

    // Compare {irq, status} against the expected value.
    task automatic chk(input string req, input logic [5:0] exp);
        n_cmp++;
        if ({irq, status} !== exp) begin
            n_bad++;
            $display("FAIL %s: got irq/status=%b expected %b", req, {irq, status}, exp);
        end
    endtask

    // Apply one cycle of stimulus, then return at the falling edge after the rising edge.
    task automatic pulse(input logic late, input logic crc, input logic fail,
                         input logic sym, input logic [1:0] v, input logic rdx,
                         input logic rt);
        ev_late = late; ev_crc = crc; crc_fail = fail; ev_sym = sym;
        sym_val = v; rd = rdx; rtask = rt;
        @(negedge clk);
        ev_late = 0; ev_crc = 0; crc_fail = 0; ev_sym = 0; sym_val = 0; rd = 0; rtask = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 during reset", 6'b0);
        rst = 1'b0;
        idle();
        chk("R1 after reset", 6'b0);
    endtask

    task automatic t_overflow();
        pulse(1, 0, 0, 0, 2'b00, 0, 0);
        chk("R2 overflow set", 6'b1_10000);
        idle();
        chk("R2 overflow holds", 6'b1_10000);
        pulse(0, 0, 0, 0, 2'b00, 1, 0);
        chk("R3 overflow read-clear", 6'b0);
    endtask

    task automatic t_crc();
        pulse(0, 1, 1, 0, 2'b00, 0, 0);
        chk("R4 crc fail", 6'b0_01000);
        pulse(0, 0, 0, 0, 2'b00, 1, 0);
        chk("R4 crc survives read", 6'b0_01000);
        pulse(0, 1, 0, 0, 2'b00, 0, 0);
        chk("R4 crc pass", 6'b0);
    endtask

    task automatic t_symbol();
        pulse(0, 0, 0, 1, 2'b10, 0, 0);
        chk("R5 symbol rx", 6'b1_00110);
        pulse(0, 0, 0, 0, 2'b00, 1, 0);
        chk("R5 value held after read", 6'b0_00010);
        pulse(0, 0, 0, 1, 2'b01, 0, 0);
        chk("R5 new symbol", 6'b1_00101);
        pulse(0, 0, 0, 0, 2'b00, 1, 0);
        chk("R9 irq drops on read", 6'b0_00001);
    endtask

    task automatic t_collide();
        pulse(1, 0, 0, 1, 2'b11, 1, 0);
        chk("R3 set during read kept", 6'b1_10111);
        pulse(0, 0, 0, 0, 2'b00, 1, 0);
        chk("R3 later read clears", 6'b0_00011);
    endtask

    task automatic t_task_clr();
        pulse(1, 1, 1, 1, 2'b10, 0, 0);
        chk("R6 setup", 6'b1_11110);
        pulse(1, 1, 1, 1, 2'b01, 0, 1);
        chk("R6 reset task wins", 6'b0);
    endtask

    task automatic t_mode_clr();
        pulse(1, 1, 1, 1, 2'b11, 0, 0);
        chk("R7 setup", 6'b1_11111);
        ev_late = 1; ev_sym = 1; sym_val = 2'b10; mps = 1'b1;
        idle();
        ev_late = 0; ev_sym = 0; sym_val = 0;
        chk("R7 psave change clears", 6'b0);
        pulse(0, 1, 1, 0, 2'b00, 0, 0);
        chk("R7 stable psave no clear", 6'b0_01000);
        mps = 1'b0;
        idle();
        chk("R7 psave back clears", 6'b0);
    endtask

    task automatic t_tx();
        pulse(0, 1, 1, 1, 2'b11, 0, 0);
        chk("R8 rx setup", 6'b1_01111);
        mtx = 1'b1;
        idle();
        chk("R8 enter tx clears", 6'b0);
        pulse(1, 1, 1, 1, 2'b11, 0, 0);
        chk("R8 tx only ready", 6'b1_00100);
        pulse(0, 0, 0, 0, 2'b00, 1, 0);
        chk("R9 tx read drops irq", 6'b0);
        mtx = 1'b0;
        idle();
        chk("R7 back to rx", 6'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_overflow();
        t_crc();
        t_symbol();
        t_collide();
        t_task_clr();
        t_mode_clr();
        t_tx();
        repeat (2) idle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule